// File: doc/BRIEF.md
# Power-Up and Reset Sequencer

This block brings a mixed-signal peripheral out of power-off in a fixed order. It watches a supply-good comparator. While that input is low, the device is held in an inactive state. Once the supply is good, the block waits out a settling interval of 26 ms. It then samples two power-mode pins to choose between normal operation and a low-power mode. In normal operation it runs a further 40 ms startup interval before it declares the device ready. Both delays are counted in clock cycles, scaled by a clocks-per-millisecond parameter.

When the normal startup interval ends, the block does three things:
- restores the configuration register to its default value, which happens when startup is entered;
- sets a reset-done flag at bit 15 of the status word;
- pulls an active-low interrupt line low.

The flag cannot be masked. The only way to release the line is for firmware to write the status address with bit 15 set. A low level on the hardware reset pin is honoured only in the normal-mode states. In that case the block returns to startup and runs the 40 ms interval again. In the low-power state the pin is ignored. Loss of supply returns the block to the inactive state from any state.

The sequencer has six named states, encoded on `seq_state`:
- OFF = 0: supply absent.
- SETTLE = 1: supply settling.
- STARTUP = 2: normal-mode startup.
- READY = 3: fully enabled.
- HWRST = 4: hardware reset held.
- LOWPWR = 5: low-power mode.

The transitions are:
- any state to OFF when `supply_ok` is low;
- OFF to SETTLE when `supply_ok` is high;
- SETTLE to STARTUP, or to LOWPWR, when the settle count expires;
- STARTUP to READY when the startup count expires;
- STARTUP or READY to HWRST when `hw_rst_n` is low;
- HWRST to STARTUP when `hw_rst_n` is high again.

Top module: `pwrup_seq`

## Requirements
- R1: While `supply_ok` is low, the state is OFF (0), `irq_n` is 1, `dev_ready` is 0 and `status_q` is 0.
- R2: After the first clock edge that sees `supply_ok` high, the state stays SETTLE (1) for exactly SETTLE_MS*CLK_PER_MS cycles. During that time the hardware reset pin is not acted on.
- R3: A normal-mode startup lasts exactly START_MS*CLK_PER_MS cycles in STARTUP (2), with `irq_n` high and `status_q` zero. The following edge enters READY (3), sets `status_q` to 16'h8000 and drives `irq_n` low.
- R4: When the settle count expires, the block goes to STARTUP only if `pm_sel1`=0 and `pm_sel0`=1. Any other pin pair goes to LOWPWR (5), which never sets the flag or lowers `irq_n`.
- R5: In STARTUP and HWRST, `cfg_q` holds CFG_DEF (8'h06) even if it was written earlier. In READY, a write to address 2 stores `wr_data[7:0]` in `cfg_q`.
- R6: In READY, a write to address 1 with bit 15 set clears the flag, and `irq_n` returns high on the next edge.
- R7: The following writes leave the flag as it was: a write to address 1 with bit 15 clear, a write to any other address, and a write while the flag is already clear.
- R8: The flag is unmaskable. No `cfg_q` value changes `irq_n`, which stays low for as long as the flag is set.
- R9: In STARTUP or READY, `hw_rst_n` low enters HWRST (4) on the next edge and clears the flag. Releasing the pin enters STARTUP, and the full startup interval runs again.
- R10: In LOWPWR, `hw_rst_n` low has no effect on state, flag or `irq_n`.
- R11: If `supply_ok` falls in any state, the block is in OFF after the next edge.
- R12: Writes are ignored outside READY.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| sys_rst_n | input | 1 | Asynchronous chip-level reset, active low |
| supply_ok | input | 1 | Supply-good comparator output |
| hw_rst_n | input | 1 | Hardware reset pin, active low |
| pm_sel0 | input | 1 | Power-mode pin 0 (high by pull-up) |
| pm_sel1 | input | 1 | Power-mode pin 1 (tie low for normal mode) |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W | Write address: 1 is status, 2 is configuration |
| wr_data | input | DATA_W | Write data |
| seq_state | output | 3 | Current sequencer state |
| dev_ready | output | 1 | High in READY |
| status_q | output | DATA_W | Status word, with the reset-done flag at bit 15 |
| cfg_q | output | CFG_W | Configuration register |
| irq_n | output | 1 | Active-low interrupt |

## Verification
The bench times both delay windows edge by edge. A design that counts one cycle too many or too few would show the flag or the state change in the wrong cycle.

A table of writes made in READY probes the write-one-to-clear rule against several patterns:
- data with bit 15 clear;
- a write to an unused address;
- a repeated clear;
- configuration values of all ones and all zeros.

A design that clears on any write, or that lets the configuration gate the interrupt, would move `irq_n` when it should not.

Directed tests cover the remaining cases:
- a hardware reset in READY;
- writes during HWRST and STARTUP;
- loss of supply during READY and during settling;
- a low-power power-up with the reset pin held low.

These catch a design that reruns no startup after a reset, keeps a stale configuration, or acts on the reset pin outside normal mode.

// File: rtl/pwrup_pkg.sv
package pwrup_pkg;

    typedef enum logic [2:0] {
        ST_OFF     = 3'd0,
        ST_SETTLE  = 3'd1,
        ST_STARTUP = 3'd2,
        ST_READY   = 3'd3,
        ST_HWRST   = 3'd4,
        ST_LOWPWR  = 3'd5
    } seq_state_e;

endpackage

// File: rtl/pwrup_timer.sv
module pwrup_timer #(
    parameter int SHORT_CYC = 52,
    parameter int LONG_CYC  = 80
) (
    input  logic clk,
    input  logic sys_rst_n,
    input  logic restart,
    input  logic run,
    input  logic use_long,
    output logic expired
);
    localparam int MAX_CYC = (SHORT_CYC > LONG_CYC) ? SHORT_CYC : LONG_CYC;
    localparam int CNT_W   = $clog2(MAX_CYC + 1);

    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] limit;

    // The limit is the last count value of the window in use.
    always_comb begin
        limit   = use_long ? CNT_W'(LONG_CYC - 1) : CNT_W'(SHORT_CYC - 1);
        expired = run && (cnt == limit);
    end

    // The count is zero in the first cycle of each state.
    always_ff @(posedge clk or negedge sys_rst_n) begin
        if (!sys_rst_n) begin
            cnt <= '0;
        end else if (restart) begin
            cnt <= '0;
        end else if (run && !expired) begin
            cnt <= cnt + 1'b1;
        end
    end

endmodule

// File: rtl/pwrup_fsm.sv
module pwrup_fsm
    import pwrup_pkg::*;
(
    input  logic       clk,
    input  logic       sys_rst_n,
    input  logic       supply_ok,
    input  logic       hw_rst_n,
    input  logic       pm_sel0,
    input  logic       pm_sel1,
    input  logic       tmr_expired,
    output seq_state_e state_q,
    output seq_state_e state_nxt,
    output logic       tmr_run,
    output logic       tmr_long,
    output logic       load_def,
    output logic       set_done,
    output logic       keep_done,
    output logic       wr_ok
);
    logic normal_pins;

    assign normal_pins = !pm_sel1 && pm_sel0;

    // State register
    always_ff @(posedge clk or negedge sys_rst_n) begin
        if (!sys_rst_n) begin
            state_q <= ST_OFF;
        end else begin
            state_q <= state_nxt;
        end
    end

    // Next-state logic. Loss of supply overrides every state.
    always_comb begin
        state_nxt = state_q;
        if (!supply_ok) begin
            state_nxt = ST_OFF;
        end else begin
            unique case (state_q)
                ST_OFF: begin
                    state_nxt = ST_SETTLE;
                end
                ST_SETTLE: begin
                    if (tmr_expired) begin
                        state_nxt = normal_pins ? ST_STARTUP : ST_LOWPWR;
                    end
                end
                ST_STARTUP: begin
                    if (!hw_rst_n) begin
                        state_nxt = ST_HWRST;
                    end else if (tmr_expired) begin
                        state_nxt = ST_READY;
                    end
                end
                ST_READY: begin
                    if (!hw_rst_n) begin
                        state_nxt = ST_HWRST;
                    end
                end
                ST_HWRST: begin
                    if (hw_rst_n) begin
                        state_nxt = ST_STARTUP;
                    end
                end
                ST_LOWPWR: begin
                    state_nxt = ST_LOWPWR;
                end
                default: begin
                    state_nxt = ST_OFF;
                end
            endcase
        end
    end

    // Control outputs to the timer and the register file
    always_comb begin
        tmr_run   = (state_q == ST_SETTLE) || (state_q == ST_STARTUP);
        tmr_long  = (state_q == ST_STARTUP);
        load_def  = ((state_nxt == ST_STARTUP) || (state_nxt == ST_HWRST))
                    && (state_nxt != state_q);
        set_done  = (state_q == ST_STARTUP) && (state_nxt == ST_READY);
        keep_done = (state_nxt == ST_READY);
        wr_ok     = (state_q == ST_READY) && (state_nxt == ST_READY);
    end

endmodule

// File: rtl/pwrup_regs.sv
module pwrup_regs #(
    parameter int                ADDR_W      = 4,
    parameter int                DATA_W      = 16,
    parameter int                DONE_BIT    = 15,
    parameter int                CFG_W       = 8,
    parameter logic [CFG_W-1:0]  CFG_DEF     = 8'h06,
    parameter logic [ADDR_W-1:0] ADDR_STATUS = 4'h1,
    parameter logic [ADDR_W-1:0] ADDR_CFG    = 4'h2
) (
    input  logic              clk,
    input  logic              sys_rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              wr_ok,
    input  logic              load_def,
    input  logic              set_done,
    input  logic              keep_done,
    output logic              rdone,
    output logic [CFG_W-1:0]  cfg_q
);
    logic clr_hit;
    logic cfg_hit;

    assign clr_hit = wr_ok && wr_en && (wr_addr == ADDR_STATUS) && wr_data[DONE_BIT];
    assign cfg_hit = wr_ok && wr_en && (wr_addr == ADDR_CFG);

    // Reset-done flag: set on entry to ready, cleared by writing a one,
    // and forced clear whenever the sequencer is not staying in ready.
    always_ff @(posedge clk or negedge sys_rst_n) begin
        if (!sys_rst_n) begin
            rdone <= 1'b0;
        end else if (set_done) begin
            rdone <= 1'b1;
        end else if (!keep_done || clr_hit) begin
            rdone <= 1'b0;
        end
    end

    always_ff @(posedge clk or negedge sys_rst_n) begin
        if (!sys_rst_n) begin
            cfg_q <= CFG_DEF;
        end else if (load_def) begin
            cfg_q <= CFG_DEF;
        end else if (cfg_hit) begin
            cfg_q <= wr_data[CFG_W-1:0];
        end
    end

endmodule

// File: rtl/pwrup_seq.sv
module pwrup_seq
    import pwrup_pkg::*;
#(
    parameter int                CLK_PER_MS  = 100000,
    parameter int                SETTLE_MS   = 26,
    parameter int                START_MS    = 40,
    parameter int                ADDR_W      = 4,
    parameter int                DATA_W      = 16,
    parameter int                DONE_BIT    = 15,
    parameter int                CFG_W       = 8,
    parameter logic [CFG_W-1:0]  CFG_DEF     = 8'h06,
    parameter logic [ADDR_W-1:0] ADDR_STATUS = 4'h1,
    parameter logic [ADDR_W-1:0] ADDR_CFG    = 4'h2
) (
    input  logic              clk,
    input  logic              sys_rst_n,
    input  logic              supply_ok,
    input  logic              hw_rst_n,
    input  logic              pm_sel0,
    input  logic              pm_sel1,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic [2:0]        seq_state,
    output logic              dev_ready,
    output logic [DATA_W-1:0] status_q,
    output logic [CFG_W-1:0]  cfg_q,
    output logic              irq_n
);
    localparam int SETTLE_CYC = SETTLE_MS * CLK_PER_MS;
    localparam int START_CYC  = START_MS * CLK_PER_MS;

    seq_state_e state_q;
    seq_state_e state_nxt;
    logic       tmr_run;
    logic       tmr_long;
    logic       tmr_expired;
    logic       load_def;
    logic       set_done;
    logic       keep_done;
    logic       wr_ok;
    logic       rdone;

    pwrup_fsm fsm_i (
        .clk         (clk),
        .sys_rst_n   (sys_rst_n),
        .supply_ok   (supply_ok),
        .hw_rst_n    (hw_rst_n),
        .pm_sel0     (pm_sel0),
        .pm_sel1     (pm_sel1),
        .tmr_expired (tmr_expired),
        .state_q     (state_q),
        .state_nxt   (state_nxt),
        .tmr_run     (tmr_run),
        .tmr_long    (tmr_long),
        .load_def    (load_def),
        .set_done    (set_done),
        .keep_done   (keep_done),
        .wr_ok       (wr_ok)
    );

    pwrup_timer #(
        .SHORT_CYC (SETTLE_CYC),
        .LONG_CYC  (START_CYC)
    ) tmr_i (
        .clk       (clk),
        .sys_rst_n (sys_rst_n),
        .restart   (state_nxt != state_q),
        .run       (tmr_run),
        .use_long  (tmr_long),
        .expired   (tmr_expired)
    );

    pwrup_regs #(
        .ADDR_W      (ADDR_W),
        .DATA_W      (DATA_W),
        .DONE_BIT    (DONE_BIT),
        .CFG_W       (CFG_W),
        .CFG_DEF     (CFG_DEF),
        .ADDR_STATUS (ADDR_STATUS),
        .ADDR_CFG    (ADDR_CFG)
    ) regs_i (
        .clk       (clk),
        .sys_rst_n (sys_rst_n),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .wr_ok     (wr_ok),
        .load_def  (load_def),
        .set_done  (set_done),
        .keep_done (keep_done),
        .rdone     (rdone),
        .cfg_q     (cfg_q)
    );

    // Interrupt has no enable: the flag alone drives the line.
    always_comb begin
        seq_state = state_q;
        dev_ready = (state_q == ST_READY);
        status_q  = '0;
        status_q[DONE_BIT] = rdone;
        irq_n     = !rdone;
    end

endmodule

// File: rtl/pwrup_seq_chk.sv
module pwrup_seq_chk
    import pwrup_pkg::*;
#(
    parameter int                ADDR_W      = 4,
    parameter int                DATA_W      = 16,
    parameter int                DONE_BIT    = 15,
    parameter int                CFG_W       = 8,
    parameter logic [CFG_W-1:0]  CFG_DEF     = 8'h06,
    parameter logic [ADDR_W-1:0] ADDR_STATUS = 4'h1
) (
    input logic              clk,
    input logic              sys_rst_n,
    input logic              supply_ok,
    input logic              hw_rst_n,
    input logic              wr_en,
    input logic [ADDR_W-1:0] wr_addr,
    input logic [DATA_W-1:0] wr_data,
    input logic [2:0]        seq_state,
    input logic [DATA_W-1:0] status_q,
    input logic [CFG_W-1:0]  cfg_q,
    input logic              irq_n
);

    p_off_when_low_r11: assert property (@(posedge clk) disable iff (!sys_rst_n)
        !supply_ok |=> (seq_state == ST_OFF));

    // R1
    p_quiet_when_off_r1: assert property (@(posedge clk) disable iff (!sys_rst_n)
        (seq_state == ST_OFF) |-> (irq_n && (status_q == '0)));

    p_flag_only_ready_r3: assert property (@(posedge clk) disable iff (!sys_rst_n)
        status_q[DONE_BIT] |-> (seq_state == ST_READY));

    p_flag_set_from_startup_r3: assert property (@(posedge clk) disable iff (!sys_rst_n)
        $rose(status_q[DONE_BIT]) |-> ($past(seq_state) == ST_STARTUP));

    p_cfg_default_r5: assert property (@(posedge clk) disable iff (!sys_rst_n)
        ((seq_state == ST_STARTUP) || (seq_state == ST_HWRST)) |-> (cfg_q == CFG_DEF));

    p_w1c_r6: assert property (@(posedge clk) disable iff (!sys_rst_n)
        ((seq_state == ST_READY) && supply_ok && hw_rst_n && wr_en
         && (wr_addr == ADDR_STATUS) && wr_data[DONE_BIT]) |=> irq_n);

    p_hwrst_enter_r9: assert property (@(posedge clk) disable iff (!sys_rst_n)
        ((seq_state == ST_READY) && supply_ok && !hw_rst_n) |=> (seq_state == ST_HWRST));

    p_lowpwr_holds_r10: assert property (@(posedge clk) disable iff (!sys_rst_n)
        ((seq_state == ST_LOWPWR) && supply_ok) |=> ((seq_state == ST_LOWPWR) && irq_n));

endmodule

bind pwrup_seq pwrup_seq_chk #(
    .ADDR_W      (ADDR_W),
    .DATA_W      (DATA_W),
    .DONE_BIT    (DONE_BIT),
    .CFG_W       (CFG_W),
    .CFG_DEF     (CFG_DEF),
    .ADDR_STATUS (ADDR_STATUS)
) chk_i (
    .clk       (clk),
    .sys_rst_n (sys_rst_n),
    .supply_ok (supply_ok),
    .hw_rst_n  (hw_rst_n),
    .wr_en     (wr_en),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data),
    .seq_state (seq_state),
    .status_q  (status_q),
    .cfg_q     (cfg_q),
    .irq_n     (irq_n)
);

// File: tb/pwrup_seq_tb_top.sv
`timescale 1ns/1ps
module pwrup_seq_tb_top;

    localparam int CPM    = 2;
    localparam int S_CYC  = 26 * CPM;
    localparam int T_CYC  = 40 * CPM;
    localparam logic [7:0] CFG_DEF = 8'h06;

    // Vector fields: {addr[3:0], data[15:0], expected flag, expected cfg[7:0]}
    localparam int NVEC = 8;
    localparam logic [28:0] VECS [NVEC] = '{
        {4'h2, 16'h00FF, 1'b1, 8'hFF},  // R8: cfg all ones, irq unchanged
        {4'h1, 16'h7FFF, 1'b1, 8'hFF},  // R7: bit 15 clear
        {4'h3, 16'hFFFF, 1'b1, 8'hFF},  // R7: other address
        {4'h2, 16'h0000, 1'b1, 8'h00},  // R8: cfg all zeros
        {4'h1, 16'h8000, 1'b0, 8'h00},  // R6: clear
        {4'h1, 16'h8000, 1'b0, 8'h00},  // R7: clear while clear
        {4'h1, 16'hFFFF, 1'b0, 8'h00},  // R7: clear while clear
        {4'h2, 16'h005A, 1'b0, 8'h5A}   // R5: cfg write in ready
    };

    logic        clk = 1'b0;
    logic        sys_rst_n;
    logic        supply_ok;
    logic        hw_rst_n;
    logic        pm_sel0;
    logic        pm_sel1;
    logic        wr_en;
    logic [3:0]  wr_addr;
    logic [15:0] wr_data;
    logic [2:0]  seq_state;
    logic        dev_ready;
    logic [15:0] status_q;
    logic [7:0]  cfg_q;
    logic        irq_n;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    pwrup_seq #(.CLK_PER_MS(CPM)) dut_i (
        .clk       (clk),
        .sys_rst_n (sys_rst_n),
        .supply_ok (supply_ok),
        .hw_rst_n  (hw_rst_n),
        .pm_sel0   (pm_sel0),
        .pm_sel1   (pm_sel1),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .seq_state (seq_state),
        .dev_ready (dev_ready),
        .status_q  (status_q),
        .cfg_q     (cfg_q),
        .irq_n     (irq_n)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check_outs(input string req, input logic [2:0] st,
                              input logic flag, input logic [7:0] cfg);
        check({req, " state"}, 32'(seq_state), 32'(st));
        check({req, " status"}, 32'(status_q), flag ? 32'h8000 : 32'h0);
        check({req, " irq_n"}, 32'(irq_n), 32'(!flag));
        check({req, " ready"}, 32'(dev_ready), 32'(st == 3'd3));
        check({req, " cfg"}, 32'(cfg_q), 32'(cfg));
    endtask

    task automatic write(input logic [3:0] a, input logic [15:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        step(1);
        wr_en = 1'b0; wr_addr = '0; wr_data = '0;
    endtask

    initial begin
        repeat (60000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        sys_rst_n = 1'b0; supply_ok = 1'b0; hw_rst_n = 1'b1;
        pm_sel0 = 1'b1; pm_sel1 = 1'b0;
        wr_en = 1'b0; wr_addr = '0; wr_data = '0;
        step(3);
        sys_rst_n = 1'b1;
        step(1);
        check_outs("R1 reset", 3'd0, 1'b0, CFG_DEF);
        step(10);
        check_outs("R1 supply low", 3'd0, 1'b0, CFG_DEF);

        // Normal power-up; hw_rst_n pulses low during settling (R2)
        supply_ok = 1'b1;
        step(1);
        check_outs("R2 settle entry", 3'd1, 1'b0, CFG_DEF);
        hw_rst_n = 1'b0;
        step(5);
        hw_rst_n = 1'b1;
        step(S_CYC - 6);
        check_outs("R2 settle end", 3'd1, 1'b0, CFG_DEF);
        step(1);
        check_outs("R4 normal pins", 3'd2, 1'b0, CFG_DEF);
        write(4'h2, 16'h00AA);
        check_outs("R12 write in startup", 3'd2, 1'b0, CFG_DEF);
        step(T_CYC - 2);
        check_outs("R3 startup end", 3'd2, 1'b0, CFG_DEF);
        step(1);
        check_outs("R3 ready", 3'd3, 1'b1, CFG_DEF);

        // Vector table in READY
        for (int i = 0; i < NVEC; i++) begin
            write(VECS[i][28:25], VECS[i][24:9]);
            check_outs($sformatf("R6/R7/R8 vec%0d", i), 3'd3, VECS[i][8], VECS[i][7:0]);
        end

        // R9: hardware reset in READY
        hw_rst_n = 1'b0;
        step(1);
        check_outs("R9 hwrst enter", 3'd4, 1'b0, CFG_DEF);
        write(4'h2, 16'h0033);
        step(3);
        check_outs("R12 write in hwrst", 3'd4, 1'b0, CFG_DEF);
        hw_rst_n = 1'b1;
        step(1);
        check_outs("R9 startup rerun", 3'd2, 1'b0, CFG_DEF);
        step(T_CYC - 1);
        check_outs("R9 startup full", 3'd2, 1'b0, CFG_DEF);
        step(1);
        check_outs("R9 ready again", 3'd3, 1'b1, CFG_DEF);

        // R9 with flag set
        hw_rst_n = 1'b0;
        step(1);
        check_outs("R9 flag cleared", 3'd4, 1'b0, CFG_DEF);
        hw_rst_n = 1'b1;
        step(T_CYC + 1);
        check_outs("R9 ready third", 3'd3, 1'b1, CFG_DEF);

        // R11: supply lost from READY
        supply_ok = 1'b0;
        step(1);
        check_outs("R11 drop ready", 3'd0, 1'b0, CFG_DEF);

        // R4/R10: low-power power-up
        pm_sel1 = 1'b1;
        supply_ok = 1'b1;
        step(S_CYC + 1);
        check_outs("R4 lowpwr", 3'd5, 1'b0, CFG_DEF);
        hw_rst_n = 1'b0;
        step(T_CYC + 5);
        check_outs("R10 reset ignored", 3'd5, 1'b0, CFG_DEF);
        hw_rst_n = 1'b1;

        // R11: supply lost during settling
        supply_ok = 1'b0;
        step(1);
        check_outs("R11 drop lowpwr", 3'd0, 1'b0, CFG_DEF);
        pm_sel1 = 1'b0;
        supply_ok = 1'b1;
        step(10);
        supply_ok = 1'b0;
        step(1);
        check_outs("R11 drop settle", 3'd0, 1'b0, CFG_DEF);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule